// File: doc/BRIEF.md
# SPI Host Segment Transfer Engine

This block is the datapath of a register-programmed SPI host. Software loads outgoing bytes into a byte-wide transmit FIFO with 32-bit word writes. It then issues a command word that names a segment length in bytes. The engine exchanges that many bytes full-duplex on the serial pins and pushes every received byte into a byte-wide receive FIFO. Software collects the received bytes with 32-bit word reads.

The serial side runs in mode 0: the clock idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge. Bits go out MSB first. The serial clock is the system clock divided by an even parameter. Chip select stays low for the whole segment and rises one serial clock period after the last byte. A segment stops early when the transmit FIFO runs dry or the receive FIFO fills. Status flags describe the FIFOs and the engine. Overflow, underflow and busy-command conditions leave the block as one-cycle pulses for an external error collector.

Top module: `sh_seg_engine`

## Requirements
- R1: After reset READY=1, TXEMPTY=1, RXEMPTY=1, ACTIVE=0, TXFULL=0, RXFULL=0, TXSTALL=0, RXSTALL=0, chip select is high and the serial clock is low.
- R2: A command is ignored while the enable bit (bit 31 of the last control write) is 0. READY stays 1, no error is raised, no stall flag is set and chip select stays high.
- R3: A command that arrives while the engine is enabled and READY is 0 gives a one-cycle command-busy error pulse. It starts no transfer and leaves the running segment's length unchanged.
- R4: An accepted command clears READY. Its bits 7:0 give the number of bytes to exchange, and its other bits have no effect. READY returns to 1 when the segment ends. A length of 0 ends the segment with no byte exchanged.
- R5: Before each byte, an empty transmit FIFO sets TXSTALL and ends the segment. Otherwise a full receive FIFO sets RXSTALL and ends the segment. Both stall flags clear when the next command is accepted.
- R6: A transmit-data write queues the four bytes of the word, bits 7:0 first. If fewer than four entries are free, only the bytes that fit are queued, TXFULL is set and one overflow error pulse is given.
- R7: A receive-data read returns, on the next cycle, up to four bytes with the oldest in bits 7:0 and clears RXFULL. Missing bytes read as 0. If fewer than four bytes were queued, RXEMPTY is set and one underflow error pulse is given. RXFULL is set when a received byte fills the receive FIFO.
- R8: At segment end the bytes left in the transmit FIFO are dropped, TXEMPTY is set, TXFULL is cleared and RXEMPTY is cleared. Chip select rises CLK_DIV system cycles after the last byte.
- R9: A control write with bit 30 set empties both FIFOs, sets TXEMPTY and RXEMPTY, clears TXFULL, RXFULL and both stall flags, aborts any segment (ACTIVE=0, chip select high, READY=1) and keeps bit 31 as the new enable.
- R10: Each byte uses eight serial clock periods of CLK_DIV system cycles each, MSB first. MISO is sampled on each rising edge. ACTIVE is 1 while a byte is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 32 | Control word: bit 31 enable, bit 30 soft reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 32 | Command word: bits 7:0 segment length |
| txd_wr_i | input | 1 | Transmit-data write strobe |
| txd_wdata_i | input | 32 | Transmit word, bits 7:0 sent first |
| rxd_rd_i | input | 1 | Receive-data read strobe |
| rxd_rdata_o | output | 32 | Receive word, valid the cycle after the strobe |
| ready_o | output | 1 | Engine can accept a command |
| active_o | output | 1 | A byte is shifting |
| txfull_o | output | 1 | A transmit byte was dropped for lack of space |
| txempty_o | output | 1 | Transmit FIFO flushed or empty |
| rxfull_o | output | 1 | Receive FIFO filled |
| rxempty_o | output | 1 | Receive FIFO ran dry on a read |
| txstall_o | output | 1 | Segment stopped on an empty transmit FIFO |
| rxstall_o | output | 1 | Segment stopped on a full receive FIFO |
| err_overflow_o | output | 1 | Overflow error pulse |
| err_underflow_o | output | 1 | Underflow error pulse |
| err_cmdbusy_o | output | 1 | Busy-command error pulse |
| sck_o | output | 1 | Serial clock, idle low |
| csn_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The assertions treat every strobe as a request for one cycle, sampled on the rising system clock edge. They also assume that MISO is steady on the system edge that raises the serial clock. The FIFO-bound assertions assume the engine never asks for more pushes than there are free entries, or more pops than there are queued bytes. The bench raises each strobe for exactly one cycle from the falling edge. It feeds MISO as the inverse of MOSI, so MISO changes only when MOSI moves on a falling serial edge. Each received byte is therefore the complement of the byte just sent.

// File: rtl/sh_seg_pkg.sv
package sh_seg_pkg;
    localparam int unsigned LANES = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_TAIL
    } seg_state_e;
endpackage

// File: rtl/sh_byte_fifo.sv
module sh_byte_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LANES = 4
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              flush_i,
    input  logic [$clog2(LANES+1)-1:0]        push_n_i,
    input  logic [LANES*8-1:0]                push_data_i,
    input  logic [$clog2(LANES+1)-1:0]        pop_n_i,
    output logic [LANES*8-1:0]                peek_o,
    output logic [$clog2(DEPTH):0]            count_o
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;
    localparam int unsigned NW = $clog2(LANES + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         wr;
        logic [AW-1:0]         rd;
        logic [CW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.wr  = s_q.wr + AW'(push_n_i);
        s_d.rd  = s_q.rd + AW'(pop_n_i);
        s_d.cnt = s_q.cnt + CW'(push_n_i) - CW'(pop_n_i);
        for (int i = 0; i < LANES; i++) begin
            if (NW'(i) < push_n_i) begin
                s_d.mem[s_q.wr + AW'(i)] = push_data_i[i*8 +: 8];
            end
        end
        if (flush_i) begin
            s_d.wr  = '0;
            s_d.rd  = '0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_peek
        assign peek_o[g*8 +: 8] = s_q.mem[s_q.rd + AW'(g)];
    end
    assign count_o = s_q.cnt;

    AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= CW'(DEPTH)); // R6
    AST_FIFO_PUSH_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        CW'(push_n_i) <= CW'(DEPTH) - s_q.cnt); // R6
    AST_FIFO_POP_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        CW'(pop_n_i) <= s_q.cnt); // R7
endmodule

// File: rtl/sh_byte_shifter.sv
module sh_byte_shifter #(
    parameter int unsigned HALF = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       abort_i,
    input  logic [7:0] tx_byte_i,
    input  logic       miso_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rx_byte_o,
    output logic       sck_o,
    output logic       mosi_o
);
    localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic [HW-1:0] cnt;
        logic [2:0]    bitn;
        logic [7:0]    sr;
        logic [7:0]    rx;
        logic          done;
    } shf_st_t;

    shf_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (abort_i) begin
            s_d.busy = 1'b0;
            s_d.sck  = 1'b0;
        end else if (start_i) begin
            s_d.busy = 1'b1;
            s_d.sck  = 1'b0;
            s_d.cnt  = '0;
            s_d.bitn = '0;
            s_d.sr   = tx_byte_i;
        end else if (s_q.busy) begin
            if (s_q.cnt == HW'(HALF - 1)) begin
                s_d.cnt = '0;
                if (!s_q.sck) begin
                    s_d.sck = 1'b1;
                    s_d.rx  = {s_q.rx[6:0], miso_i};
                end else begin
                    s_d.sck = 1'b0;
                    if (s_q.bitn == 3'd7) begin
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.bitn = s_q.bitn + 3'd1;
                        s_d.sr   = {s_q.sr[6:0], 1'b0};
                    end
                end
            end else begin
                s_d.cnt = s_q.cnt + HW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o    = s_q.busy;
    assign done_o    = s_q.done;
    assign rx_byte_o = s_q.rx;
    assign sck_o     = s_q.sck;
    assign mosi_o    = s_q.sr[7];

    AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.busy |-> !s_q.sck); // R10
    AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> !s_q.busy); // R10
endmodule

// File: rtl/sh_seg_engine.sv
module sh_seg_engine
    import sh_seg_pkg::*;
#(
    parameter int unsigned TX_DEPTH = 16,
    parameter int unsigned RX_DEPTH = 16,
    parameter int unsigned CLK_DIV  = 2
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        ctrl_wr_i,
    input  logic [31:0] ctrl_wdata_i,
    input  logic        cmd_wr_i,
    input  logic [31:0] cmd_wdata_i,
    input  logic        txd_wr_i,
    input  logic [31:0] txd_wdata_i,
    input  logic        rxd_rd_i,
    output logic [31:0] rxd_rdata_o,
    output logic        ready_o,
    output logic        active_o,
    output logic        txfull_o,
    output logic        txempty_o,
    output logic        rxfull_o,
    output logic        rxempty_o,
    output logic        txstall_o,
    output logic        rxstall_o,
    output logic        err_overflow_o,
    output logic        err_underflow_o,
    output logic        err_cmdbusy_o,
    output logic        sck_o,
    output logic        csn_o,
    output logic        mosi_o,
    input  logic        miso_i
);
    localparam int unsigned TCW  = $clog2(TX_DEPTH) + 1;
    localparam int unsigned RCW  = $clog2(RX_DEPTH) + 1;
    localparam int unsigned NW   = $clog2(LANES + 1);
    localparam int unsigned HALF = CLK_DIV / 2;
    localparam int unsigned TW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        seg_state_e  st;
        logic [7:0]  len;
        logic [TW-1:0] tail;
        logic        en;
        logic        ready;
        logic        txfull;
        logic        txempty;
        logic        rxfull;
        logic        rxempty;
        logic        txstall;
        logic        rxstall;
        logic        e_ovf;
        logic        e_unf;
        logic        e_busy;
        logic [31:0] rdata;
    } eng_st_t;

    localparam eng_st_t RST_VAL = '{st: ST_IDLE, len: '0, tail: '0, en: 1'b0,
        ready: 1'b1, txfull: 1'b0, txempty: 1'b1, rxfull: 1'b0, rxempty: 1'b1,
        txstall: 1'b0, rxstall: 1'b0, e_ovf: 1'b0, e_unf: 1'b0, e_busy: 1'b0,
        rdata: '0};

    eng_st_t s_d, s_q;

    logic [NW-1:0]      tx_push_n, rx_pop_n;
    logic               tx_pop, rx_push, tx_flush, rx_flush, sh_start, sh_abort;
    logic [LANES*8-1:0] tx_peek, rx_peek;
    logic [TCW-1:0]     tx_count, tx_free;
    logic [RCW-1:0]     rx_count;
    logic               sh_busy, sh_done;
    logic [7:0]         sh_rx;

    assign tx_free = TCW'(TX_DEPTH) - tx_count;

    always_comb begin
        s_d        = s_q;
        s_d.e_ovf  = 1'b0;
        s_d.e_unf  = 1'b0;
        s_d.e_busy = 1'b0;
        tx_push_n  = '0;
        rx_pop_n   = '0;
        tx_pop     = 1'b0;
        rx_push    = 1'b0;
        tx_flush   = 1'b0;
        rx_flush   = 1'b0;
        sh_start   = 1'b0;
        sh_abort   = 1'b0;

        if (txd_wr_i) begin
            tx_push_n = (tx_free < TCW'(LANES)) ? NW'(tx_free) : NW'(LANES);
            if (tx_free < TCW'(LANES)) begin
                s_d.txfull = 1'b1;
                s_d.e_ovf  = 1'b1;
            end
            if (tx_push_n != '0) s_d.txempty = 1'b0;
        end

        if (cmd_wr_i && s_q.en) begin
            if (!s_q.ready) begin
                s_d.e_busy = 1'b1;
            end else begin
                s_d.ready   = 1'b0;
                s_d.len     = cmd_wdata_i[7:0];
                s_d.txstall = 1'b0;
                s_d.rxstall = 1'b0;
                s_d.st      = ST_LOAD;
            end
        end

        case (s_q.st)
            ST_LOAD: begin
                s_d.tail = '0;
                if (s_q.len == 8'd0) begin
                    s_d.st = ST_TAIL;
                end else if (tx_count == '0) begin
                    s_d.txstall = 1'b1;
                    s_d.st      = ST_TAIL;
                end else if (rx_count == RCW'(RX_DEPTH)) begin
                    s_d.rxstall = 1'b1;
                    s_d.st      = ST_TAIL;
                end else begin
                    tx_pop   = 1'b1;
                    sh_start = 1'b1;
                    s_d.st   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    rx_push = 1'b1;
                    if (rx_count == RCW'(RX_DEPTH - 1)) s_d.rxfull = 1'b1;
                    s_d.len = s_q.len - 8'd1;
                    s_d.st  = ST_LOAD;
                end
            end
            ST_TAIL: begin
                if (s_q.tail == TW'(CLK_DIV - 1)) begin
                    s_d.st      = ST_IDLE;
                    s_d.ready   = 1'b1;
                    tx_flush    = 1'b1;
                    s_d.txempty = 1'b1;
                    s_d.txfull  = 1'b0;
                    s_d.rxempty = 1'b0;
                end else begin
                    s_d.tail = s_q.tail + TW'(1);
                end
            end
            default: ;
        endcase

        if (rxd_rd_i) begin
            rx_pop_n   = (rx_count < RCW'(LANES)) ? NW'(rx_count) : NW'(LANES);
            s_d.rxfull = 1'b0;
            for (int i = 0; i < LANES; i++) begin
                s_d.rdata[i*8 +: 8] = (NW'(i) < rx_pop_n) ? rx_peek[i*8 +: 8] : 8'h00;
            end
            if (rx_count < RCW'(LANES)) begin
                s_d.rxempty = 1'b1;
                s_d.e_unf   = 1'b1;
            end
        end

        if (ctrl_wr_i) begin
            s_d.en = ctrl_wdata_i[31];
            if (ctrl_wdata_i[30]) begin
                s_d       = RST_VAL;
                s_d.en    = ctrl_wdata_i[31];
                s_d.rdata = s_q.rdata;
                tx_flush  = 1'b1;
                rx_flush  = 1'b1;
                tx_push_n = '0;
                rx_pop_n  = '0;
                tx_pop    = 1'b0;
                rx_push   = 1'b0;
                sh_start  = 1'b0;
                sh_abort  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= RST_VAL;
        else         s_q <= s_d;
    end

    sh_byte_fifo #(.DEPTH(TX_DEPTH), .LANES(LANES)) u_txq (
        .clk_i, .rst_ni, .flush_i(tx_flush), .push_n_i(tx_push_n),
        .push_data_i(txd_wdata_i), .pop_n_i(NW'(tx_pop)),
        .peek_o(tx_peek), .count_o(tx_count));

    sh_byte_fifo #(.DEPTH(RX_DEPTH), .LANES(LANES)) u_rxq (
        .clk_i, .rst_ni, .flush_i(rx_flush), .push_n_i(NW'(rx_push)),
        .push_data_i({{(LANES-1)*8{1'b0}}, sh_rx}), .pop_n_i(rx_pop_n),
        .peek_o(rx_peek), .count_o(rx_count));

    sh_byte_shifter #(.HALF(HALF)) u_shf (
        .clk_i, .rst_ni, .start_i(sh_start), .abort_i(sh_abort),
        .tx_byte_i(tx_peek[7:0]), .miso_i, .busy_o(sh_busy), .done_o(sh_done),
        .rx_byte_o(sh_rx), .sck_o, .mosi_o);

    assign rxd_rdata_o     = s_q.rdata;
    assign ready_o         = s_q.ready;
    assign active_o        = (s_q.st == ST_SHIFT);
    assign txfull_o        = s_q.txfull;
    assign txempty_o       = s_q.txempty;
    assign rxfull_o        = s_q.rxfull;
    assign rxempty_o       = s_q.rxempty;
    assign txstall_o       = s_q.txstall;
    assign rxstall_o       = s_q.rxstall;
    assign err_overflow_o  = s_q.e_ovf;
    assign err_underflow_o = s_q.e_unf;
    assign err_cmdbusy_o   = s_q.e_busy;
    assign csn_o           = (s_q.st == ST_IDLE);

    AST_DISABLED_CMD_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr_i && !s_q.en && s_q.ready && !ctrl_wr_i) |=> (s_q.ready && !err_cmdbusy_o)); // R2
    AST_BUSY_CMD_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr_i && s_q.en && !s_q.ready && !ctrl_wr_i) |=> err_cmdbusy_o); // R3
    AST_STALL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(s_q.txstall && s_q.rxstall)); // R5
    AST_SEG_END_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(csn_o) && !$past(ctrl_wr_i) && !$past(rxd_rd_i))
        |-> (s_q.txempty && !s_q.rxempty && !s_q.txfull && s_q.ready)); // R8
    AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr_i && ctrl_wdata_i[30])
        |=> (s_q.txempty && s_q.rxempty && s_q.ready && csn_o && !active_o)); // R9
    AST_SHIFT_IN_SEGMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sh_busy |-> (s_q.st == ST_SHIFT)); // R10
endmodule

// File: tb/sh_seg_engine_tb_top.sv
module sh_seg_engine_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        ctrl_wr = 0, cmd_wr = 0, txd_wr = 0, rxd_rd = 0;
    logic [31:0] ctrl_wdata = 0, cmd_wdata = 0, txd_wdata = 0;
    logic [31:0] rxd_rdata;
    logic ready, active, txfull, txempty, rxfull, rxempty, txstall, rxstall;
    logic e_ovf, e_unf, e_busy, sck, csn, mosi, miso;

    assign miso = ~mosi;

    sh_seg_engine dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
        .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
        .txd_wr_i(txd_wr), .txd_wdata_i(txd_wdata),
        .rxd_rd_i(rxd_rd), .rxd_rdata_o(rxd_rdata),
        .ready_o(ready), .active_o(active), .txfull_o(txfull), .txempty_o(txempty),
        .rxfull_o(rxfull), .rxempty_o(rxempty), .txstall_o(txstall), .rxstall_o(rxstall),
        .err_overflow_o(e_ovf), .err_underflow_o(e_unf), .err_cmdbusy_o(e_busy),
        .sck_o(sck), .csn_o(csn), .mosi_o(mosi), .miso_i(miso));

    int total = 0, bad = 0;
    int cap_n = 0, bits = 0, cyc = 0;
    int n_ovf = 0, n_unf = 0, n_busy = 0;
    logic [7:0] cap [64];
    logic [7:0] sh = 0;
    logic sck_prev = 0, seen_active = 0;

    always @(posedge clk) begin
        logic [7:0] nb;
        cyc++;
        if (e_ovf)  n_ovf++;
        if (e_unf)  n_unf++;
        if (e_busy) n_busy++;
        if (active) seen_active = 1;
        if (csn) bits = 0;
        else if (sck && !sck_prev) begin
            nb = {sh[6:0], mosi};
            sh = nb;
            bits++;
            if (bits == 8) begin
                cap[cap_n % 64] = nb;
                cap_n++;
                bits = 0;
            end
        end
        sck_prev = sck;
        if (cyc == 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = d;
        @(negedge clk); ctrl_wr = 0;
    endtask
    task automatic wr_cmd(input logic [31:0] d);
        @(negedge clk); cmd_wr = 1; cmd_wdata = d;
        @(negedge clk); cmd_wr = 0;
    endtask
    task automatic wr_tx(input logic [31:0] d);
        @(negedge clk); txd_wr = 1; txd_wdata = d;
        @(negedge clk); txd_wr = 0;
    endtask
    task automatic rd_rx(output logic [31:0] w);
        @(negedge clk); rxd_rd = 1;
        @(negedge clk); rxd_rd = 0; w = rxd_rdata;
    endtask
    task automatic settle();
        repeat (2) @(negedge clk);
    endtask
    task automatic wait_ready();
        int n = 0;
        @(negedge clk);
        while (!ready && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) chk("wait_ready timeout", 0, 1);
    endtask

    // {length, word}
    localparam logic [39:0] VEC [4] = '{40'h04_A5C3_0F81, 40'h01_1234_5678,
                                        40'h03_DEAD_BEEF, 40'h02_0BAD_F00D};

    initial begin
        logic [31:0] r, w, e;
        int c0, u0, b0;
        logic [7:0] len;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", ready, 1);
        chk("R1 txempty/rxempty", {txempty, rxempty}, 2'b11);
        chk("R1 flags", {active, txfull, rxfull, txstall, rxstall}, 0);
        chk("R1 csn/sck", {csn, sck}, 2'b10);

        // R2 command while disabled
        wr_cmd(32'h4);
        settle();
        chk("R2 ready", ready, 1);
        chk("R2 no stall/csn", {txstall, csn}, 2'b01);
        chk("R2 no bytes/busy", cap_n + n_busy, 0);

        wr_ctrl(32'h8000_0000);

        // R4 R6 R7 R10 table of segments
        for (int i = 0; i < 4; i++) begin
            w = VEC[i][31:0];
            len = VEC[i][39:32];
            c0 = cap_n;
            u0 = n_unf;
            wr_tx(w);
            wr_cmd({18'd0, 2'(i), 2'(3 - i), 1'(i), 1'b0, len});
            chk("R4 ready low", ready, 0);
            wait_ready();
            chk("R4 byte count", cap_n - c0, 32'(len));
            for (int j = 0; j < int'(len); j++)
                chk("R10 mosi byte", cap[(c0 + j) % 64], w[j*8 +: 8]);
            chk("R8 txempty", txempty, 1);
            rd_rx(r);
            e = 0;
            for (int j = 0; j < int'(len); j++) e[j*8 +: 8] = ~w[j*8 +: 8];
            chk("R7 rx word", r, e);
            settle();
            chk("R7 underflow", n_unf - u0, (len < 4) ? 1 : 0);
        end
        chk("R10 active seen", seen_active, 1);

        // R8 leftover flush then R5 tx stall
        wr_tx(32'h0403_0201);
        wr_tx(32'h0807_0605);
        wr_cmd(32'h2);
        wait_ready();
        rd_rx(r);
        chk("R7 two bytes", r, 32'h0000_FDFE);
        c0 = cap_n;
        wr_cmd(32'h1);
        wait_ready();
        chk("R5 txstall", {txstall, rxstall}, 2'b10);
        chk("R8 leftovers dropped", cap_n - c0, 0);

        // R3 busy command
        b0 = n_busy;
        c0 = cap_n;
        wr_tx(32'h55AA_33CC);
        wr_cmd(32'h4);
        wr_cmd(32'h1);
        wait_ready();
        settle();
        chk("R3 busy pulse", n_busy - b0, 1);
        chk("R3 length kept", cap_n - c0, 4);
        chk("R5 stall cleared", txstall, 0);
        rd_rx(r);
        chk("R3 rx word", r, ~32'h55AA_33CC);

        // R6 overflow, R7 rxfull, R5 rx stall
        c0 = cap_n;
        for (int k = 0; k < 5; k++)
            wr_tx({8'(8'h33 + 4*k), 8'(8'h32 + 4*k), 8'(8'h31 + 4*k), 8'(8'h30 + 4*k)});
        settle();
        chk("R6 overflow pulse", n_ovf, 1);
        chk("R6 txfull", txfull, 1);
        wr_cmd(32'h10);
        wait_ready();
        chk("R6 bytes sent", cap_n - c0, 16);
        for (int j = 0; j < 16; j++) chk("R6 byte order", cap[(c0 + j) % 64], 8'(8'h30 + j));
        chk("R7 rxfull", rxfull, 1);
        chk("R8 txfull cleared", txfull, 0);
        c0 = cap_n;
        wr_tx(32'h1);
        wr_cmd(32'h1);
        wait_ready();
        chk("R5 rxstall", {txstall, rxstall}, 2'b01);
        chk("R5 no byte", cap_n - c0, 0);
        u0 = n_unf;
        for (int k = 0; k < 4; k++) begin
            rd_rx(r);
            chk("R7 full drain", r, ~{8'(8'h33 + 4*k), 8'(8'h32 + 4*k), 8'(8'h31 + 4*k), 8'(8'h30 + 4*k)});
            if (k == 0) chk("R7 rxfull cleared", rxfull, 0);
        end
        settle();
        chk("R7 no underflow", n_unf - u0, 0);

        // R4 zero length
        c0 = cap_n;
        wr_cmd(32'h0);
        chk("R4 len0 ready low", ready, 0);
        wait_ready();
        chk("R4 len0 no bytes", cap_n - c0, 0);
        chk("R8 rxempty cleared", rxempty, 0);

        // R9 soft reset mid segment
        wr_tx(32'hCAFE_F00D);
        wr_cmd(32'h4);
        repeat (8) @(negedge clk);
        chk("R10 active mid byte", active, 1);
        wr_ctrl(32'hC000_0000);
        chk("R9 idle", {active, csn, ready}, 3'b011);
        chk("R9 empties", {txempty, rxempty, txfull, rxfull}, 4'b1100);
        u0 = n_unf;
        rd_rx(r);
        settle();
        chk("R9 rx empty read", r, 0);
        chk("R9 underflow", n_unf - u0, 1);
        c0 = cap_n;
        wr_tx(32'h0000_0096);
        wr_cmd(32'h1);
        wait_ready();
        chk("R9 enable kept", cap_n - c0, 1);
        chk("R9 byte after reset", cap[c0 % 64], 8'h96);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule